// File: doc/BRIEF.md
# Page-Table Walk Miss Handler

When a lookup misses in the address-translation buffer, this block finds the missing mapping in a single-level page table in memory and decides what happens next. It takes the virtual page number, the kind of access that missed (read, write or instruction fetch) and the table base of the running process. From these it forms the address of the 4-byte table entry and fetches that entry over a plain request / read-valid memory port. It then classifies the entry.

The walk ends in exactly one of four ways:
- **Segmentation fault:** the entry is not valid.
- **Protection fault:** the entry's rights do not allow the access.
- **Page fault:** the entry is allowed but the page is not resident.
- **Insert:** the translation is written into the translation buffer and a retry of the faulting access is signalled.

The table base is sampled per miss, so it can be reloaded freely on a context switch between walks. While a walk is in progress the block is busy and ignores new misses.

Top module: `xlat_miss_walker`

## Requirements
- R1: While reset is asserted and after it is released, busy, the memory request and all outcome outputs are low until a miss is accepted.
- R2: A miss is accepted only in a cycle where busy is low and miss_valid_i is high. Busy is high from the cycle after acceptance up to and including the outcome cycle. Misses presented while busy is high are ignored.
- R3: In the cycle after acceptance, mem_req_o is high for exactly one cycle. During that cycle mem_addr_o equals base + vpn*4, taken modulo 2^32, using the base and VPN captured at acceptance. Later changes on those inputs are ignored.
- R4: Read data is taken only from a mem_rvalid_i pulse that arrives after the request cycle while the walk waits. A pulse in the request cycle or while idle is ignored. The outcome appears two cycles after the accepted read-valid cycle.
- R5: Entry layout is as follows. Bits 31:12 hold the physical page number, bit 5 is valid, bit 4 is present and bit 3 is dirty. Bits 2, 1 and 0 grant read, write and execute. Access codes are 0 read, 1 write, 2 execute; code 3 is never permitted.
- R6: An entry with the valid bit clear gives a segmentation fault, whatever its other bits are.
- R7: A valid entry that does not grant the requested access gives a protection fault, whether or not it is present.
- R8: A valid, permitted, present entry raises tlb_wr_o and retry_o together. The insert fields carry the captured VPN, the entry's page number, its read/write/execute bits on tlb_rights_o[2:0] and its dirty bit.
- R9: A valid, permitted entry with the present bit clear gives a page fault.
- R10: Each accepted miss produces exactly one outcome, lasting one cycle. In the next cycle the block is idle and can accept a new miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_valid_i | input | 1 | Translation miss presented |
| miss_vpn_i | input | VPN_W | Virtual page number of the miss |
| miss_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| table_base_i | input | AW | Page-table base of the current process |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | One-cycle read request for the table entry |
| mem_addr_o | output | AW | Byte address of the table entry |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Table entry read from memory |
| tlb_wr_o | output | 1 | Insert translation into the buffer |
| tlb_vpn_o | output | VPN_W | VPN to insert |
| tlb_ppn_o | output | 20 | Physical page number to insert |
| tlb_rights_o | output | 3 | Read, write, execute rights (bit 2..0) |
| tlb_dirty_o | output | 1 | Dirty bit to insert |
| retry_o | output | 1 | Retry the faulting access |
| seg_fault_o | output | 1 | Segmentation fault |
| prot_fault_o | output | 1 | Protection fault |
| page_fault_o | output | 1 | Page fault |

## Verification
The properties rely only on miss_valid_i and mem_rvalid_i being at defined levels once the internal reset is released. They are reset by that synchronised reset, so a miss offered during the release window does not count against them. No property demands that memory ever answers; the stimulus always returns a response within a few cycles. It drives every input from time zero and changes inputs only 2 ns after a rising edge. Misses are presented with fields that change while busy, and stray read-valid pulses are issued while idle and in the request cycle.

// File: rtl/xlat_walk_pkg.sv
package xlat_walk_pkg;

  localparam int unsigned ENTRY_W = 32;
  localparam int unsigned FRAME_W = 20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_CHECK,
    ST_DONE
  } walk_state_e;

  typedef enum logic [2:0] {
    RES_NONE,
    RES_INSERT,
    RES_SEG,
    RES_PROT,
    RES_PAGE
  } walk_res_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // Table entry as stored in memory.
  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic [5:0]         spare;
    logic               valid;
    logic               present;
    logic               dirty;
    logic               can_rd;
    logic               can_wr;
    logic               can_ex;
  } pte_t;

endpackage

// File: rtl/xlat_walk_fsm.sv
module xlat_walk_fsm
  import xlat_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rsp_i,
  output walk_state_e state_o,
  output logic        accept_o,
  output logic        take_rsp_o,
  output logic        judge_o
);

  walk_state_e st_q;
  walk_state_e st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (rsp_i) st_d = ST_CHECK;
      ST_CHECK: st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o    = st_q;
  assign accept_o   = (st_q == ST_IDLE) && start_i;
  assign take_rsp_o = (st_q == ST_WAIT) && rsp_i;
  assign judge_o    = (st_q == ST_CHECK);

endmodule

// File: rtl/xlat_pte_addr.sv
module xlat_pte_addr #(
  parameter int unsigned VPN_W       = 20,
  parameter int unsigned AW          = 32,
  parameter int unsigned ENTRY_BYTES = 4
) (
  input  logic [AW-1:0]    base_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [AW-1:0]    addr_o
);

  localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);

  logic [AW-1:0] vpn_wide;

  assign vpn_wide = AW'(vpn_i);
  // Sum wraps modulo 2^AW.
  assign addr_o   = base_i + (vpn_wide << SHIFT);

endmodule

// File: rtl/xlat_pte_classify.sv
module xlat_pte_classify
  import xlat_walk_pkg::*;
(
  input  pte_t      pte_i,
  input  logic [1:0] acc_i,
  output walk_res_e res_o
);

  logic allowed;
  logic field_unused;

  // Page number, dirty and spare bits play no part in the decision.
  assign field_unused = ^{pte_i.frame, pte_i.spare, pte_i.dirty};

  always_comb begin
    case (acc_kind_e'(acc_i))
      ACC_READ:  allowed = pte_i.can_rd;
      ACC_WRITE: allowed = pte_i.can_wr;
      ACC_EXEC:  allowed = pte_i.can_ex;
      default:   allowed = 1'b0;
    endcase
  end

  // Priority: validity, then rights, then residency.
  always_comb begin
    if (!pte_i.valid)        res_o = RES_SEG;
    else if (!allowed)       res_o = RES_PROT;
    else if (pte_i.present)  res_o = RES_INSERT;
    else                     res_o = RES_PAGE;
  end

endmodule

// File: rtl/xlat_miss_walker.sv
module xlat_miss_walker
  import xlat_walk_pkg::*;
#(
  parameter int unsigned VPN_W       = 20,
  parameter int unsigned AW          = 32,
  parameter int unsigned ENTRY_BYTES = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid_i,
  input  logic [VPN_W-1:0]   miss_vpn_i,
  input  logic [1:0]         miss_acc_i,
  input  logic [AW-1:0]      table_base_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic [AW-1:0]      mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [ENTRY_W-1:0] mem_rdata_i,
  output logic               tlb_wr_o,
  output logic [VPN_W-1:0]   tlb_vpn_o,
  output logic [FRAME_W-1:0] tlb_ppn_o,
  output logic [2:0]         tlb_rights_o,
  output logic               tlb_dirty_o,
  output logic               retry_o,
  output logic               seg_fault_o,
  output logic               prot_fault_o,
  output logic               page_fault_o
);

  logic rst_sync_n;

  // Reset: asserted at once, released after SYNC_STAGES clock edges.
  generate
    if (SYNC_STAGES < 2) begin : g_rst_one
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign rst_sync_n = q;
    end else begin : g_rst_chain
      logic [SYNC_STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = q[SYNC_STAGES-1];
    end
  endgenerate

  walk_state_e state;
  logic        accept;
  logic        take_rsp;
  logic        judge;

  xlat_walk_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (miss_valid_i),
    .rsp_i      (mem_rvalid_i),
    .state_o    (state),
    .accept_o   (accept),
    .take_rsp_o (take_rsp),
    .judge_o    (judge)
  );

  // Miss context, captured once per walk.
  logic [VPN_W-1:0] vpn_q;
  logic [1:0]       acc_q;
  logic [AW-1:0]    base_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vpn_q  <= '0;
      acc_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      vpn_q  <= miss_vpn_i;
      acc_q  <= miss_acc_i;
      base_q <= table_base_i;
    end
  end

  xlat_pte_addr #(
    .VPN_W       (VPN_W),
    .AW          (AW),
    .ENTRY_BYTES (ENTRY_BYTES)
  ) u_addr (
    .base_i (base_q),
    .vpn_i  (vpn_q),
    .addr_o (mem_addr_o)
  );

  // Fetched entry.
  pte_t pte_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   pte_q <= '0;
    else if (take_rsp) pte_q <= pte_t'(mem_rdata_i);
  end

  walk_res_e res_d;
  walk_res_e res_q;

  xlat_pte_classify u_cls (
    .pte_i (pte_q),
    .acc_i (acc_q),
    .res_o (res_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) res_q <= RES_NONE;
    else if (judge)  res_q <= res_d;
  end

  logic in_done;

  assign in_done      = (state == ST_DONE);
  assign busy_o       = (state != ST_IDLE);
  assign mem_req_o    = (state == ST_ISSUE);

  assign tlb_wr_o     = in_done && (res_q == RES_INSERT);
  assign retry_o      = in_done && (res_q == RES_INSERT);
  assign seg_fault_o  = in_done && (res_q == RES_SEG);
  assign prot_fault_o = in_done && (res_q == RES_PROT);
  assign page_fault_o = in_done && (res_q == RES_PAGE);

  assign tlb_vpn_o    = vpn_q;
  assign tlb_ppn_o    = pte_q.frame;
  assign tlb_rights_o = {pte_q.can_rd, pte_q.can_wr, pte_q.can_ex};
  assign tlb_dirty_o  = pte_q.dirty;

endmodule

// File: rtl/xlat_walk_chk.sv
module xlat_walk_chk (
  input logic clk,
  input logic rst_n,
  input logic miss_valid_i,
  input logic busy_o,
  input logic mem_req_o,
  input logic mem_rvalid_i,
  input logic tlb_wr_o,
  input logic retry_o,
  input logic seg_fault_o,
  input logic prot_fault_o,
  input logic page_fault_o
);

  logic any_out;
  assign any_out = tlb_wr_o | seg_fault_o | prot_fault_o | page_fault_o;

  // R2
  accept_starts_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && miss_valid_i) |=> (busy_o && mem_req_o));

  // R2
  busy_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(miss_valid_i));

  // R2
  busy_in_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> busy_o);

  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);

  // R4
  outcome_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> $past(mem_rvalid_i, 2));

  // R8
  retry_pairs_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr_o == retry_o);

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tlb_wr_o, seg_fault_o, prot_fault_o, page_fault_o}));

  // R10
  idle_after_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |=> (!busy_o && !any_out));

endmodule

bind xlat_miss_walker xlat_walk_chk u_walk_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .miss_valid_i (miss_valid_i),
  .busy_o       (busy_o),
  .mem_req_o    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i),
  .tlb_wr_o     (tlb_wr_o),
  .retry_o      (retry_o),
  .seg_fault_o  (seg_fault_o),
  .prot_fault_o (prot_fault_o),
  .page_fault_o (page_fault_o)
);

// File: tb/test_xlat_miss_walker.sv
`timescale 1ns/1ps
module test_xlat_miss_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [19:0] miss_vpn = '0;
  logic [1:0]  miss_acc = '0;
  logic [31:0] table_base = '0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic        busy_o, mem_req_o, tlb_wr_o, tlb_dirty_o, retry_o;
  logic        seg_fault_o, prot_fault_o, page_fault_o;
  logic [31:0] mem_addr_o;
  logic [19:0] tlb_vpn_o, tlb_ppn_o;
  logic [2:0]  tlb_rights_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  xlat_miss_walker i_xlat_miss_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid_i (miss_valid),
    .miss_vpn_i   (miss_vpn),
    .miss_acc_i   (miss_acc),
    .table_base_i (table_base),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata),
    .tlb_wr_o     (tlb_wr_o),
    .tlb_vpn_o    (tlb_vpn_o),
    .tlb_ppn_o    (tlb_ppn_o),
    .tlb_rights_o (tlb_rights_o),
    .tlb_dirty_o  (tlb_dirty_o),
    .retry_o      (retry_o),
    .seg_fault_o  (seg_fault_o),
    .prot_fault_o (prot_fault_o),
    .page_fault_o (page_fault_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // R5 layout: frame[31:12], valid 5, present 4, dirty 3, rd 2, wr 1, ex 0
  function automatic logic [31:0] mk_pte(input logic [19:0] frame, input bit v, input bit p,
                                         input bit d, input bit r, input bit w, input bit x);
    return {frame, 6'b0, v, p, d, r, w, x};
  endfunction

  // Expected outcome vector {tlb_wr, retry, seg, prot, page} from R6..R9
  function automatic logic [4:0] exp_out(input logic [31:0] p, input logic [1:0] a);
    bit ok;
    ok = (a == 2'd0 && p[2]) || (a == 2'd1 && p[1]) || (a == 2'd2 && p[0]);
    if (!p[5])     return 5'b00100;
    else if (!ok)  return 5'b00010;
    else if (p[4]) return 5'b11000;
    else           return 5'b00001;
  endfunction

  function automatic string out_tag(input logic [4:0] e, input bit in_rst);
    if (in_rst)    return "R1";
    if (e[4])      return "R8";
    if (e[2])      return "R6";
    if (e[1])      return "R7";
    if (e[0])      return "R9";
    return "R4/R10";
  endfunction

  // Behavioural reference: phase 0 idle, 1 request, 2 waiting, 3 judging, 4 outcome.
  int          m_ph;
  logic [19:0] m_vpn;
  logic [1:0]  m_acc;
  logic [31:0] m_addr;
  logic [31:0] m_pte;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_ph = 0;
    else begin
      case (m_ph)
        0: if (miss_valid) begin
             m_vpn  = miss_vpn;
             m_acc  = miss_acc;
             m_addr = table_base + ({12'b0, miss_vpn} * 32'd4);
             m_ph   = 1;
           end
        1: m_ph = 2;
        2: if (mem_rvalid) begin m_pte = mem_rdata; m_ph = 3; end
        3: m_ph = 4;
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    logic [4:0] e;
    logic [4:0] a;
    bit         r;
    r = !rst_n;
    check(busy_o === (m_ph != 0), r ? "R1" : "R2", 64'(busy_o), 64'(m_ph != 0));
    check(mem_req_o === (m_ph == 1), r ? "R1" : "R3", 64'(mem_req_o), 64'(m_ph == 1));
    if (m_ph == 1)
      check(mem_addr_o === m_addr, "R3", 64'(mem_addr_o), 64'(m_addr));
    e = (m_ph == 4) ? exp_out(m_pte, m_acc) : 5'b0;
    a = {tlb_wr_o, retry_o, seg_fault_o, prot_fault_o, page_fault_o};
    check(a === e, out_tag(e, r), 64'(a), 64'(e));
    if (e[4]) begin
      check(tlb_vpn_o === m_vpn, "R8 vpn", 64'(tlb_vpn_o), 64'(m_vpn));
      check(tlb_ppn_o === m_pte[31:12], "R5 R8 ppn", 64'(tlb_ppn_o), 64'(m_pte[31:12]));
      check(tlb_rights_o === m_pte[2:0], "R5 R8 rights", 64'(tlb_rights_o), 64'(m_pte[2:0]));
      check(tlb_dirty_o === m_pte[3], "R5 R8 dirty", 64'(tlb_dirty_o), 64'(m_pte[3]));
    end
  end

  // One walk. hold: keep a different miss offered while busy (R2).
  // stray: junk read-valid in the request cycle (R4). lat: extra wait cycles.
  task automatic run_miss(input logic [19:0] vpn, input logic [1:0] acc, input logic [31:0] base,
                          input logic [31:0] pte, input int lat, input bit hold, input bit stray);
    @(posedge clk); #2;
    miss_valid = 1'b1; miss_vpn = vpn; miss_acc = acc; table_base = base;
    @(posedge clk); #2;                       // request cycle
    table_base = 32'hDEAD_BEEF;               // R3: must not affect address
    if (hold) begin miss_vpn = vpn ^ 20'h5A5A5; miss_acc = ~acc; end
    else miss_valid = 1'b0;
    if (stray) begin mem_rvalid = 1'b1; mem_rdata = ~pte; end
    @(posedge clk); #2;                       // waiting
    mem_rvalid = 1'b0; mem_rdata = 32'hFFFF_FFFF;
    for (int i = 0; i < lat; i++) begin @(posedge clk); #2; end
    mem_rvalid = 1'b1; mem_rdata = pte; miss_valid = 1'b0;
    @(posedge clk); #2;                       // judging
    mem_rvalid = 1'b0; mem_rdata = 32'h0;
    @(posedge clk); #2;                       // outcome
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 explicit reset-state check
    check({busy_o, mem_req_o, tlb_wr_o, retry_o, seg_fault_o, prot_fault_o, page_fault_o} === 7'b0,
          "R1", 64'({busy_o, mem_req_o, tlb_wr_o, retry_o, seg_fault_o, prot_fault_o, page_fault_o}), 64'd0);

    // R4: stray read-valid while idle is ignored
    @(posedge clk); #2; mem_rvalid = 1'b1; mem_rdata = 32'h0;
    @(posedge clk); #2; mem_rvalid = 1'b0;

    // R8 read, present, lat 0
    run_miss(20'h00005, 2'd0, 32'h0000_1000, mk_pte(20'hABCDE, 1, 1, 0, 1, 0, 0), 0, 0, 0);
    // R7 write to read-only page
    run_miss(20'h00123, 2'd1, 32'h0040_0000, mk_pte(20'h11111, 1, 1, 0, 1, 0, 1), 1, 0, 0);
    // R9 exec allowed but not present
    run_miss(20'hFFFFF, 2'd2, 32'h1000_0000, mk_pte(20'h22222, 1, 0, 0, 0, 0, 1), 2, 0, 0);
    // R6 invalid although all rights and present
    run_miss(20'h0BEEF, 2'd0, 32'h2000_0000, mk_pte(20'h33333, 0, 1, 1, 1, 1, 1), 0, 0, 0);
    // R6 invalid and absent, access reserved
    run_miss(20'h00001, 2'd3, 32'h2000_0000, mk_pte(20'h00000, 0, 0, 0, 0, 0, 0), 0, 0, 0);
    // R5 R7 reserved access code with all rights
    run_miss(20'h00777, 2'd3, 32'h3000_0000, mk_pte(20'h44444, 1, 1, 0, 1, 1, 1), 0, 0, 0);
    // R7 protection beats absent page
    run_miss(20'h00888, 2'd2, 32'h3000_0000, mk_pte(20'h55555, 1, 0, 0, 1, 1, 0), 0, 0, 0);
    // R2 R8 write, dirty, long latency, other miss held while busy
    run_miss(20'h12345, 2'd1, 32'h0800_0000, mk_pte(20'hFEDCB, 1, 1, 1, 0, 1, 0), 3, 1, 0);
    // R3 address wraps modulo 2^32
    run_miss(20'h00800, 2'd2, 32'hFFFF_F000, mk_pte(20'h0F0F0, 1, 1, 0, 0, 0, 1), 0, 0, 0);
    // R4 stray read-valid in request cycle ignored
    run_miss(20'h0AAAA, 2'd0, 32'h0000_0000, mk_pte(20'h76543, 1, 1, 0, 1, 1, 0), 1, 0, 1);
    // R10 back-to-back misses
    run_miss(20'h00010, 2'd1, 32'h0001_0000, mk_pte(20'h00020, 1, 0, 1, 0, 1, 0), 0, 0, 0);
    run_miss(20'h00011, 2'd0, 32'h0001_0000, mk_pte(20'h00021, 1, 1, 0, 1, 0, 0), 0, 0, 0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R10 watchdog expired: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule